// File: doc/BRIEF.md
# Two-Bit Instruction Sequencer

This block is the control half of a small two-register processor. It holds a two-bit opcode and runs a two-state controller that drives the select lines of the surrounding datapath. The datapath has three multiplexers: a source multiplexer in front of register A, a source multiplexer in front of register B, and a result multiplexer that picks what appears on the output bus. The opcode is taken from the two low bits of the input bus.

Each instruction takes two clock cycles. In the first cycle, the fetch cycle, the opcode register captures the low bus bits. Both data registers hold their values, and the output bus shows register A. In the second cycle, the execute cycle, the select lines are decoded directly from the stored opcode, and one data register is written. The controller then returns to fetch. Because the execute-cycle selects are conditional on the opcode, no state per instruction is needed.

Source multiplexer codes, used for both A and B: 00 is the input bus, 01 is register A, 10 is register B and 11 is the output bus. Result multiplexer codes used here: 011 passes register A, 110 is register A shifted left by one bit, and 111 is A + B + carry-in.

Top module: `instr_sequencer`

## Requirements
- R1: A synchronous reset puts the controller in the fetch cycle and clears the opcode register. The first cycle after reset shows the fetch outputs.
- R2: In a fetch cycle the outputs are opLoad=1, aSel=01 (A holds), bSel=10 (B holds) and outSel=011 (output shows A). The opcode register captures opIn at the closing edge of that cycle.
- R3: Fetch and execute cycles strictly alternate, so opLoad reads 1,0,1,0… and every instruction lasts two cycles.
- R4: Opcode 00 in execute gives opLoad=0, aSel=01, bSel=01 and outSel=011. This copies A into B.
- R5: Opcode 01 in execute gives opLoad=0, aSel=00, bSel=10 and outSel=011. This loads the input bus into A.
- R6: Opcode 10 in execute gives opLoad=0, aSel=11, bSel=10 and outSel=110. This writes A shifted left by one bit back into A.
- R7: Opcode 11 in execute gives opLoad=0, aSel=11, bSel=10 and outSel=111. This writes A+B+carry-in back into A, and the sum wraps at the register width.
- R8: A change on opIn during an execute cycle has no effect on that cycle's selects.
- R9: Reset acts only at a clock edge. Asserting it partway through an execute cycle leaves that cycle's outputs unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opIn | input | 2 | Low two bits of the input bus, the opcode source |
| opLoad | output | 1 | Load strobe of the opcode register, high in fetch |
| aSel | output | 2 | Source select for register A |
| bSel | output | 2 | Source select for register B |
| outSel | output | 3 | Result multiplexer select |

## Verification
The bench drives a small datapath model from the select outputs and runs a short program: load 5, copy it to B, double A, then add with carry-in so the sum wraps to zero. A decoder that mixes up the shift and add codes, or the A and B hold codes, leaves the wrong values in the registers. The bench changes opIn during an execute cycle to catch a decoder that reads the bus instead of the stored opcode. It raises reset partway through a cycle to catch a reset that acts without waiting for the clock edge. It also checks the fetch/execute alternation, so a controller that stalls in one state or skips fetch breaks the expected pattern.

// File: rtl/instr_seq_pkg.sv
package instr_seq_pkg;
  localparam int OP_W   = 2;
  localparam int SRC_W  = 2;
  localparam int RES_W  = 3;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_EXEC  = 1'b1
  } seqState_t;

  // strobes from the controller to the opcode register
  typedef struct packed {
    logic loadOp;
  } ctrlStrobe_t;

  // source select codes
  localparam logic [SRC_W-1:0] SRC_BUS  = 2'b00;
  localparam logic [SRC_W-1:0] SRC_A    = 2'b01;
  localparam logic [SRC_W-1:0] SRC_B    = 2'b10;
  localparam logic [SRC_W-1:0] SRC_RES  = 2'b11;

  // result select codes
  localparam logic [RES_W-1:0] RES_PASSA = 3'b011;
  localparam logic [RES_W-1:0] RES_SHL   = 3'b110;
  localparam logic [RES_W-1:0] RES_SUM   = 3'b111;

  // opcodes
  localparam logic [OP_W-1:0] OP_COPYB = 2'b00;
  localparam logic [OP_W-1:0] OP_LOADA = 2'b01;
  localparam logic [OP_W-1:0] OP_SHLA  = 2'b10;
  localparam logic [OP_W-1:0] OP_ADDA  = 2'b11;
endpackage

// File: rtl/opcode_reg.sv
module opcode_reg
  import instr_seq_pkg::*;
#(
  parameter int WIDTH = OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] opCode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      opCode <= '0;
    end else if (strobe.loadOp) begin
      opCode <= busIn;
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import instr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opCode,
  output ctrlStrobe_t      strobe,
  output logic [SRC_W-1:0] aSel,
  output logic [SRC_W-1:0] bSel,
  output logic [RES_W-1:0] outSel
);
  seqState_t curState, nxtState;

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_FETCH;
    else     curState <= nxtState;
  end

  always_comb begin
    nxtState = (curState == ST_FETCH) ? ST_EXEC : ST_FETCH;
  end

  always_comb begin
    strobe.loadOp = 1'b0;
    aSel          = SRC_A;
    bSel          = SRC_B;
    outSel        = RES_PASSA;
    if (curState == ST_FETCH) begin
      strobe.loadOp = 1'b1;
    end else begin
      unique case (opCode)
        OP_COPYB: bSel = SRC_A;
        OP_LOADA: aSel = SRC_BUS;
        OP_SHLA: begin
          aSel   = SRC_RES;
          outSel = RES_SHL;
        end
        OP_ADDA: begin
          aSel   = SRC_RES;
          outSel = RES_SUM;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import instr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opIn,
  output logic             opLoad,
  output logic [SRC_W-1:0] aSel,
  output logic [SRC_W-1:0] bSel,
  output logic [RES_W-1:0] outSel
);
  ctrlStrobe_t           strobe;
  logic [OP_W-1:0]       opCode;

  opcode_reg #(.WIDTH(OP_W)) u_opReg (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .busIn  (opIn),
    .opCode (opCode)
  );

  seq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opCode (opCode),
    .strobe (strobe),
    .aSel   (aSel),
    .bSel   (bSel),
    .outSel (outSel)
  );

  assign opLoad = strobe.loadOp;
endmodule

// File: rtl/instr_sequencer_chk.sv
module instr_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] opIn,
  input logic       opLoad,
  input logic [1:0] aSel,
  input logic [1:0] bSel,
  input logic [2:0] outSel
);
  AST_RESET_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> opLoad); // R1
  AST_FETCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    opLoad |-> (aSel == 2'b01 && bSel == 2'b10 && outSel == 3'b011)); // R2
  AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (rst)
    opLoad |=> !opLoad); // R3
  AST_EXEC_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
    !opLoad |=> opLoad); // R3
  AST_EXEC_COPY: assert property (@(posedge clk) disable iff (rst)
    (!opLoad && $past(opIn) == 2'b00) |-> (bSel == 2'b01 && aSel == 2'b01)); // R4
  AST_EXEC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!opLoad && $past(opIn) == 2'b01) |-> (aSel == 2'b00 && bSel == 2'b10)); // R5
  AST_EXEC_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!opLoad && $past(opIn) == 2'b10) |-> (outSel == 3'b110 && aSel == 2'b11)); // R6
  AST_EXEC_SUM: assert property (@(posedge clk) disable iff (rst)
    (!opLoad && $past(opIn) == 2'b11) |-> (outSel == 3'b111 && aSel == 2'b11)); // R7
endmodule

bind instr_sequencer instr_sequencer_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .opIn   (opIn),
  .opLoad (opLoad),
  .aSel   (aSel),
  .bSel   (bSel),
  .outSel (outSel)
);

// File: tb/instr_sequencer_tb.sv
module instr_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dataIn = '0;
  logic       cin = 1'b0;
  logic       opLoad;
  logic [1:0] aSel, bSel;
  logic [2:0] outSel;
  logic [3:0] regA, regB, resBus;
  int nChecks = 0;
  int nFails  = 0;

  localparam logic [7:0] V_FETCH = 8'b1_01_10_011;
  localparam logic [7:0] V_OP00  = 8'b0_01_01_011;
  localparam logic [7:0] V_OP01  = 8'b0_00_10_011;
  localparam logic [7:0] V_OP10  = 8'b0_11_10_110;
  localparam logic [7:0] V_OP11  = 8'b0_11_10_111;

  always #10 clk = ~clk;

  instr_sequencer u_dut (
    .clk(clk), .rst(rst), .opIn(dataIn[1:0]),
    .opLoad(opLoad), .aSel(aSel), .bSel(bSel), .outSel(outSel)
  );

  // datapath model driven only by the select outputs
  always_comb begin
    case (outSel)
      3'b011:  resBus = regA;
      3'b110:  resBus = {regA[2:0], 1'b0};
      3'b111:  resBus = regA + regB + {3'b000, cin};
      default: resBus = 4'h0;
    endcase
  end

  function automatic logic [3:0] pick(logic [1:0] s);
    case (s)
      2'b00:   return dataIn;
      2'b01:   return regA;
      2'b10:   return regB;
      default: return resBus;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      regA <= '0;
      regB <= '0;
    end else begin
      regA <= pick(aSel);
      regB <= pick(bSel);
    end
  end

  function automatic logic [7:0] outs();
    return {opLoad, aSel, bSel, outSel};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 reset outputs", outs(), V_FETCH);
    rst = 1'b0;
  endtask

  // runs one instruction starting at a fetch cycle (called just after a negedge)
  task automatic runOp(logic [3:0] fetchBus, logic [3:0] execBus, logic [7:0] expExec, string req);
    dataIn = fetchBus;
    check("R2 fetch outputs", outs(), V_FETCH);
    @(negedge clk);
    dataIn = execBus;
    check(req, outs(), expExec);
    check("R3 exec strobe low", {7'b0, opLoad}, 8'h00);
    @(negedge clk);
    check("R3 back to fetch", {7'b0, opLoad}, 8'h01);
  endtask

  task automatic testDecode();
    doReset();
    runOp(4'h0, 4'h0, V_OP00, "R4 copy decode");
    runOp(4'h1, 4'h0, V_OP01, "R5 load decode");
    runOp(4'h2, 4'h0, V_OP10, "R6 shift decode");
    runOp(4'h3, 4'h0, V_OP11, "R7 sum decode");
  endtask

  task automatic testProgram();
    doReset();
    cin = 1'b0;
    runOp(4'h1, 4'h5, V_OP01, "R5 load decode");
    check("R5 A loaded", {4'h0, regA}, 8'h05);
    runOp(4'h0, 4'h0, V_OP00, "R4 copy decode");
    check("R4 B copied", {4'h0, regB}, 8'h05);
    runOp(4'h2, 4'h0, V_OP10, "R6 shift decode");
    check("R6 A doubled", {4'h0, regA}, 8'h0A);
    cin = 1'b1;
    runOp(4'h3, 4'h0, V_OP11, "R7 sum decode");
    check("R7 A wrapped sum", {4'h0, regA}, 8'h00);
    check("R7 B unchanged", {4'h0, regB}, 8'h05);
    cin = 1'b0;
  endtask

  task automatic testHold();
    doReset();
    dataIn = 4'h2;
    @(negedge clk);
    dataIn = 4'h1;
    #2 check("R8 opIn change ignored", outs(), V_OP10);
    dataIn = 4'h0;
    #2 check("R8 opIn change ignored", outs(), V_OP10);
    @(negedge clk);
  endtask

  task automatic testSyncReset();
    doReset();
    dataIn = 4'h3;
    @(negedge clk);
    rst = 1'b1;
    #3 check("R9 reset waits for edge", outs(), V_OP11);
    @(negedge clk);
    check("R9 reset lands in fetch", outs(), V_FETCH);
    rst = 1'b0;
  endtask

  initial begin
    fork
      begin
        testDecode();
        testProgram();
        testHold();
        testSyncReset();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule